// File: doc/BRIEF.md
# Half-Bridge PWM Input Conditioner

This block sits between the controller's two PWM lines for one half-bridge phase and the gate command outputs for the high-side and low-side switches. Each input is first resynchronised to the core clock, then passed through a programmable spike filter. Pulses of either polarity shorter than the filter window are dropped. Edges that are accepted reach the outputs after a fixed latency. A polarity strap can make both inputs active-low.

In direct mode the two filtered inputs command the two switches independently. When both inputs ask for conduction at the same time, the interlock switches both outputs off. In local mode only the top input is used: the high side follows it and the low side takes its complement. A guard interval of a programmable number of cycles, with both switches off, separates one switch turning off from the other turning on. An active-low safe pin forces the command to zero. In direct mode this leaves both switches off, and in local mode it leaves the low side conducting. A drive-enable input from the phase fault manager clears both outputs combinationally and overrides every other rule.

The sequencer has seven states: `ST_D_IDLE`, `ST_D_HI` and `ST_D_LO` for direct mode, and `ST_L_HI`, `ST_L_LO`, `ST_L_GAP_HI` and `ST_L_GAP_LO` for local mode. In direct mode every cycle selects `ST_D_HI`, `ST_D_LO` or `ST_D_IDLE` from the filtered inputs, whatever the current state. On entering local mode, a direct state moves to `ST_L_GAP_HI` if the command is high and to `ST_L_GAP_LO` if it is low. In local mode the transitions are:
- `ST_L_HI` moves to `ST_L_GAP_LO` when the command falls.
- `ST_L_LO` moves to `ST_L_GAP_HI` when the command rises.
- A gap state moves to the opposite gap state, with its timer cleared, when the command reverses.
- `ST_L_GAP_HI` moves to `ST_L_HI`, and `ST_L_GAP_LO` moves to `ST_L_LO`, once the guard interval has elapsed.

Top module: `hb_pwm_cond`

## Requirements
- R1: While system reset `rst_n` is low, both gate outputs are 0.
- R2: A level on an input (after polarity) that lasts fewer than FILT_CYC clock cycles has no effect on either output, for both high-going and low-going pulses; a level held FILT_CYC cycles or more is accepted.
- R3: An accepted input edge reaches its gate output on the FILT_CYC+3rd rising clock edge after the input changes (two synchroniser stages, the filter and the state register); after FILT_CYC+2 edges the output is unchanged.
- R4: In direct mode (`local_mode_i`=0) the top input alone turns on `gate_hi_o` and the bottom input alone turns on `gate_lo_o`.
- R5: In direct mode, while both filtered inputs are active, both outputs are 0.
- R6: In local mode (`local_mode_i`=1) `gate_hi_o` follows the top input and `gate_lo_o` its complement; the bottom input has no effect.
- R7: In local mode, exactly NOV_CYC cycles with both outputs 0 separate one output falling from the other rising.
- R8: A command reversal during a guard interval restarts the interval toward the new side; the side that just turned off is not turned back on and no output pulse appears.
- R9: While `safe_n_i` is low the command is forced to 0: in direct mode both outputs are 0; in local mode `gate_hi_o` is 0 and `gate_lo_o` turns on after the guard interval.
- R10: With `act_low_i`=1, an input at 0 is the active level and an input at 1 is inactive.
- R11: While `drv_en_i` is 0 both outputs are 0 within the same cycle, in any mode.
- R12: An input held at its active level indefinitely keeps its output on (100% duty cycle).
- R13: The two gate outputs are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| pwm_top_i | input | 1 | High-side PWM request (also the single source in local mode) |
| pwm_bot_i | input | 1 | Low-side PWM request (direct mode only) |
| local_mode_i | input | 1 | 1 = local complementary mode, 0 = direct mode |
| act_low_i | input | 1 | 1 = PWM inputs are active low |
| safe_n_i | input | 1 | Safe-state pin, active low, forces the command to 0 |
| drv_en_i | input | 1 | Drive enable from the fault manager; 0 clears both outputs |
| gate_hi_o | output | 1 | High-side gate command |
| gate_lo_o | output | 1 | Low-side gate command |

## Verification
The properties assume that `local_mode_i` and `act_low_i` are static straps. The guard-interval and hold properties therefore test that local mode was also set one cycle earlier, and the stimulus changes the mode only between test phases, never inside a guard interval. The properties also assume that inputs change at most once per clock. The bench drives every input on the falling edge, so each value is held for a full cycle before it is sampled. Pulse lengths sit just below and at the filter window, and the reversal during a guard interval is placed so that the filtered edge lands well inside the interval.

// File: rtl/hb_pwm_pkg.sv
package hb_pwm_pkg;

    typedef enum logic [2:0] {
        ST_D_IDLE,
        ST_D_HI,
        ST_D_LO,
        ST_L_HI,
        ST_L_LO,
        ST_L_GAP_HI,
        ST_L_GAP_LO
    } cond_st_e;

    // width of a counter running 0 .. n-1
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/hb_pwm_sync.sv
module hb_pwm_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/hb_pwm_glitch.sv
module hb_pwm_glitch
    import hb_pwm_pkg::*;
#(
    parameter int FILT_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    localparam int             CW       = cnt_bits(FILT_CYC);
    localparam logic [CW-1:0]  RUN_LAST = CW'(FILT_CYC - 1);

    logic          val_q;
    logic [CW-1:0] run_q;

    // a differing level must persist FILT_CYC samples before it is taken
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= 1'b0;
            run_q <= '0;
        end else if (din != val_q) begin
            if (run_q == RUN_LAST) begin
                val_q <= din;
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    assign dout = val_q;

endmodule

// File: rtl/hb_pwm_fsm.sv
module hb_pwm_fsm
    import hb_pwm_pkg::*;
#(
    parameter int NOV_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic local_mode,
    input  logic safe_ok,
    input  logic flt_top,
    input  logic flt_bot,
    output logic hi_o,
    output logic lo_o
);

    localparam int            CW       = cnt_bits(NOV_CYC);
    localparam logic [CW-1:0] GAP_LAST = CW'(NOV_CYC - 1);

    cond_st_e      st_q, st_d;
    logic [CW-1:0] gap_q;
    logic          cmd, want_hi, want_lo, gap_done, in_gap_d;

    assign cmd      = safe_ok & flt_top;
    assign want_hi  = safe_ok & flt_top & ~flt_bot;
    assign want_lo  = safe_ok & flt_bot & ~flt_top;
    assign gap_done = (gap_q == GAP_LAST);
    assign in_gap_d = (st_d == ST_L_GAP_HI) || (st_d == ST_L_GAP_LO);

    always_comb begin
        st_d = st_q;
        if (!local_mode) begin
            if (want_hi)      st_d = ST_D_HI;
            else if (want_lo) st_d = ST_D_LO;
            else              st_d = ST_D_IDLE;
        end else begin
            unique case (st_q)
                ST_D_IDLE, ST_D_HI, ST_D_LO:
                    st_d = cmd ? ST_L_GAP_HI : ST_L_GAP_LO;
                ST_L_HI:
                    if (!cmd) st_d = ST_L_GAP_LO;
                ST_L_LO:
                    if (cmd) st_d = ST_L_GAP_HI;
                ST_L_GAP_HI:
                    if (!cmd)          st_d = ST_L_GAP_LO;
                    else if (gap_done) st_d = ST_L_HI;
                ST_L_GAP_LO:
                    if (cmd)           st_d = ST_L_GAP_HI;
                    else if (gap_done) st_d = ST_L_LO;
                default:
                    st_d = ST_D_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_D_IDLE;
        else        st_q <= st_d;
    end

    // guard timer: runs while staying in one gap state, cleared otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        gap_q <= '0;
        else if (in_gap_d && st_d == st_q) gap_q <= gap_q + 1'b1;
        else                               gap_q <= '0;
    end

    always_comb begin
        hi_o = (st_q == ST_D_HI) || (st_q == ST_L_HI);
        lo_o = (st_q == ST_D_LO) || (st_q == ST_L_LO);
    end

endmodule

// File: rtl/hb_pwm_cond.sv
module hb_pwm_cond #(
    parameter int FILT_CYC    = 100,
    parameter int NOV_CYC     = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_top_i,
    input  logic pwm_bot_i,
    input  logic local_mode_i,
    input  logic act_low_i,
    input  logic safe_n_i,
    input  logic drv_en_i,
    output logic gate_hi_o,
    output logic gate_lo_o
);

    localparam int NCH = 2;

    logic [NCH:0]   raw, synced;
    logic [NCH-1:0] flt;
    logic           flt_top, flt_bot, safe_ok, hi_q, lo_q;

    assign raw = {safe_n_i, pwm_bot_i ^ act_low_i, pwm_top_i ^ act_low_i};

    hb_pwm_sync #(.W(NCH + 1), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (synced)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_filt
        hb_pwm_glitch #(.FILT_CYC(FILT_CYC)) filt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (synced[ch]),
            .dout  (flt[ch])
        );
    end

    assign flt_top = flt[0];
    assign flt_bot = flt[1];
    assign safe_ok = synced[NCH];

    hb_pwm_fsm #(.NOV_CYC(NOV_CYC)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .local_mode (local_mode_i),
        .safe_ok    (safe_ok),
        .flt_top    (flt_top),
        .flt_bot    (flt_bot),
        .hi_o       (hi_q),
        .lo_o       (lo_q)
    );

    assign gate_hi_o = hi_q & drv_en_i;
    assign gate_lo_o = lo_q & drv_en_i;

endmodule

// File: rtl/hb_pwm_cond_chk.sv
module hb_pwm_cond_chk (
    input logic clk,
    input logic rst_n,
    input logic local_mode_i,
    input logic drv_en_i,
    input logic gate_hi_o,
    input logic gate_lo_o,
    input logic hi_q,
    input logic lo_q,
    input logic flt_top,
    input logic flt_bot,
    input logic safe_ok
);

    // R13
    both_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_o && gate_lo_o));

    // R11
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en_i |-> (!gate_hi_o && !gate_lo_o));

    // R5
    interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!local_mode_i && flt_top && flt_bot) |=> (!hi_q && !lo_q));

    // R7
    gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (local_mode_i && $past(local_mode_i) && $fell(lo_q)) |-> !hi_q);

    // R9
    safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (local_mode_i && !safe_ok) |=> !hi_q);

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (local_mode_i && $past(local_mode_i) && hi_q && safe_ok && flt_top) |=> hi_q);

endmodule

bind hb_pwm_cond hb_pwm_cond_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .local_mode_i (local_mode_i),
    .drv_en_i     (drv_en_i),
    .gate_hi_o    (gate_hi_o),
    .gate_lo_o    (gate_lo_o),
    .hi_q         (hi_q),
    .lo_q         (lo_q),
    .flt_top      (flt_top),
    .flt_bot      (flt_bot),
    .safe_ok      (safe_ok)
);

// File: tb/hb_pwm_cond_tb.sv
`timescale 1ns/1ps
module hb_pwm_cond_tb_top;

    localparam int FILT = 16;
    localparam int NOV  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_top = 1'b0, pwm_bot = 1'b0, local_mode = 1'b0;
    logic act_low = 1'b0, safe_n = 1'b1, drv_en = 1'b1;
    logic gate_hi, gate_lo;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0, done = 1'b0;

    always #2.5 clk = ~clk;

    hb_pwm_cond #(.FILT_CYC(FILT), .NOV_CYC(NOV)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwm_top_i    (pwm_top),
        .pwm_bot_i    (pwm_bot),
        .local_mode_i (local_mode),
        .act_low_i    (act_low),
        .safe_n_i     (safe_n),
        .drv_en_i     (drv_en),
        .gate_hi_o    (gate_hi),
        .gate_lo_o    (gate_lo)
    );

    // behavioural reference: sampled history, run lengths, guard countdown
    bit [2:0] m_p1, m_p2;
    bit       m_ft, m_fb, mhi, mlo, inloc;
    int       run_t, run_b, mgap, mcnt;

    always @(posedge clk) begin
        bit cmd, dh, dl;
        int w;
        if (!rst_n) begin
            m_p1 = '0; m_p2 = '0; m_ft = 0; m_fb = 0;
            run_t = 0; run_b = 0; mhi = 0; mlo = 0; inloc = 0; mgap = 0; mcnt = 0;
        end else begin
            cmd = m_p2[2] & m_ft;
            dh  = m_p2[2] & m_ft & ~m_fb;
            dl  = m_p2[2] & m_fb & ~m_ft;
            if (!local_mode) begin
                mhi = dh; mlo = dl; inloc = 0; mgap = 0;
            end else if (!inloc) begin
                inloc = 1; mhi = 0; mlo = 0; mgap = cmd ? 1 : 2; mcnt = 0;
            end else if (mgap == 0) begin
                if (mhi && !cmd) begin mhi = 0; mgap = 2; mcnt = 0; end
                else if (mlo && cmd) begin mlo = 0; mgap = 1; mcnt = 0; end
            end else begin
                w = cmd ? 1 : 2;
                if (w != mgap) begin mgap = w; mcnt = 0; end
                else if (mcnt == NOV - 1) begin
                    if (mgap == 1) mhi = 1; else mlo = 1;
                    mgap = 0;
                end else mcnt++;
            end
            if (m_p2[0] != m_ft) begin
                run_t++;
                if (run_t == FILT) begin m_ft = m_p2[0]; run_t = 0; end
            end else run_t = 0;
            if (m_p2[1] != m_fb) begin
                run_b++;
                if (run_b == FILT) begin m_fb = m_p2[1]; run_b = 0; end
            end else run_b = 0;
            m_p2 = m_p1;
            m_p1 = {safe_n, pwm_bot ^ act_low, pwm_top ^ act_low};
        end
    end

    // compare on every clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (cmp_on && !done) begin
            n_chk++;
            if (gate_hi !== (mhi & drv_en) || gate_lo !== (mlo & drv_en)) begin
                n_fail++;
                $display("FAIL %s model: hi=%b lo=%b expected hi=%b lo=%b at %0t",
                         cur_req, gate_hi, gate_lo, mhi & drv_en, mlo & drv_en, $time);
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int gap, seen;
        cmp_on = 1'b1;
        // R1 reset
        cyc(5);
        chk("R1 hi in reset", gate_hi, 1'b0);
        chk("R1 lo in reset", gate_lo, 1'b0);
        rst_n = 1'b1;
        cyc(10);

        // R3 / R4 direct top
        cur_req = "R4";
        pwm_top = 1'b1;
        cyc(FILT + 2);
        chk("R3 before latency", gate_hi, 1'b0);
        cyc(1);
        chk("R3 at latency", gate_hi, 1'b1);
        cyc(50);
        pwm_top = 1'b0; cyc(60);
        pwm_bot = 1'b1; cyc(60);
        chk("R4 bottom drives lo", gate_lo, 1'b1);
        chk("R4 hi stays off", gate_hi, 1'b0);
        pwm_bot = 1'b0; cyc(60);

        // R2 glitch rejection, both polarities and the boundary
        cur_req = "R2";
        pwm_top = 1'b1; cyc(FILT - 1); pwm_top = 1'b0;
        seen = 0;
        for (int i = 0; i < 60; i++) begin cyc(1); if (gate_hi) seen = 1; end
        chk("R2 short high pulse dropped", seen[0], 1'b0);
        pwm_top = 1'b1; cyc(60);
        pwm_top = 1'b0; cyc(FILT - 1); pwm_top = 1'b1;
        seen = 0;
        for (int i = 0; i < 60; i++) begin cyc(1); if (!gate_hi) seen = 1; end
        chk("R2 short low pulse dropped", seen[0], 1'b0);
        pwm_top = 1'b0; cyc(60);
        pwm_top = 1'b1; cyc(FILT); pwm_top = 1'b0;
        seen = 0;
        for (int i = 0; i < 60; i++) begin cyc(1); if (gate_hi) seen = 1; end
        chk("R2 full-window pulse accepted", seen[0], 1'b1);

        // R5 interlock
        cur_req = "R5";
        pwm_top = 1'b1; cyc(60);
        pwm_bot = 1'b1; cyc(60);
        chk("R5 hi blocked", gate_hi, 1'b0);
        chk("R5 lo blocked", gate_lo, 1'b0);
        pwm_top = 1'b0; cyc(60);
        chk("R5 lo after release", gate_lo, 1'b1);
        pwm_bot = 1'b0; cyc(60);

        // R10 active-low inputs
        cur_req = "R10";
        act_low = 1'b1; pwm_top = 1'b1; pwm_bot = 1'b1; cyc(60);
        chk("R10 high is inactive", gate_hi, 1'b0);
        pwm_top = 1'b0; cyc(60);
        chk("R10 low is active", gate_hi, 1'b1);
        pwm_top = 1'b1; cyc(60);
        act_low = 1'b0; pwm_top = 1'b0; pwm_bot = 1'b0; cyc(60);

        // R11 drive enable
        cur_req = "R11";
        pwm_top = 1'b1; cyc(60);
        drv_en = 1'b0; #1;
        chk("R11 hi cleared same cycle", gate_hi, 1'b0);
        cyc(10);
        drv_en = 1'b1; cyc(5);
        chk("R11 hi back", gate_hi, 1'b1);

        // R9 safe pin, direct
        cur_req = "R9";
        safe_n = 1'b0; cyc(10);
        chk("R9 direct hi off", gate_hi, 1'b0);
        chk("R9 direct lo off", gate_lo, 1'b0);
        safe_n = 1'b1; pwm_top = 1'b0; cyc(60);

        // R6 / R7 local mode
        cur_req = "R6";
        local_mode = 1'b1; cyc(100);
        chk("R6 lo is complement", gate_lo, 1'b1);
        pwm_top = 1'b1;
        gap = 0;
        for (int i = 0; i < 400; i++) begin
            cyc(1);
            if (gate_hi) break;
            if (!gate_lo) gap++;
        end
        chk("R7 guard length", (gap == NOV), 1'b1);
        if (gap != NOV) $display("FAIL R7: actual=%0d expected=%0d", gap, NOV);
        pwm_bot = 1'b1; cyc(80);
        chk("R6 bottom ignored hi", gate_hi, 1'b1);
        chk("R6 bottom ignored lo", gate_lo, 1'b0);
        pwm_bot = 1'b0;

        // R12 continuous on
        cur_req = "R12";
        cyc(2000);
        chk("R12 hi still on", gate_hi, 1'b1);

        // R8 reversal inside the guard interval
        cur_req = "R8";
        pwm_top = 1'b0;
        seen = 0;
        for (int i = 0; i < 24; i++) begin cyc(1); if (gate_lo) seen = 1; end
        pwm_top = 1'b1;
        for (int i = 0; i < 150; i++) begin cyc(1); if (gate_lo) seen = 1; end
        chk("R8 lo never pulsed", seen[0], 1'b0);
        chk("R8 hi restored", gate_hi, 1'b1);

        // R9 safe pin, local
        cur_req = "R9";
        safe_n = 1'b0; cyc(10);
        chk("R9 local hi off", gate_hi, 1'b0);
        cyc(100);
        chk("R9 local lo on", gate_lo, 1'b1);
        safe_n = 1'b1; cyc(150);
        chk("R13 after safe release", gate_hi & gate_lo, 1'b0);

        cur_req = "R13";
        local_mode = 1'b0; pwm_top = 1'b0; cyc(60);
        finish_run();
    end

endmodule